// File: doc/BRIEF.md
# Masked interrupt pending controller

This block gathers the interrupt causes of one serial port channel into a four-bit source-pending register. A mask register hides any of them, and a single level-sensitive interrupt line is driven from the result. Each cause arrives as a one-cycle event pulse. The receive, error and modem pulses come from the receive path and the modem-line logic. The transmit pulse marks a byte being written into the transmit holding register.

The block also raises the transmit cause by itself while the transmit FIFO is running low. In FIFO mode it compares the current transmit fill count with a trigger level. That level is the trigger field scaled by a factor fixed per instance by the `CHANNEL` parameter. Software uses three write targets on a simple register strobe: it clears causes through the pending view or the source view, and it loads the mask. Register writes are always accepted in the cycle they are strobed; there is no back-pressure. All state is visible on the output ports for the register read path.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Source bit positions are receive = 0, error = 1, transmit = 2, modem = 3. An event pulse sets its bit at the next clock edge, and the bit then holds until it is cleared.
- R2: `pend` equals `src_pend` AND NOT `mask` in every cycle. `irq` is high exactly when `pend` is nonzero. Masking a set source hides it from `pend` and `irq` but leaves `src_pend` set.
- R3: A write with `wr_sel` = 0 (pending view) clears every source bit whose `wr_data` bit is 1, so those bits also leave `pend`. This happens whether or not those bits are masked.
- R4: A write with `wr_sel` = 1 (source view) clears the source bits written as 1 and leaves bits written as 0 unchanged.
- R5: A write with `wr_sel` = 2 loads `mask` from `wr_data` at that edge, so `pend` and `irq` follow from the next cycle. The write does not change `src_pend`.
- R6: The transmit trigger level is `tx_trig` times 32 when `CHANNEL` is 0, times 8 when it is 1 or 4, and times 2 when it is 2 or 3. For any other channel the level is 0.
- R7: While `fifo_en` is high and `tx_count` is less than or equal to the trigger level, the transmit source bit is set at every edge. A clear written in such a cycle does not remove it.
- R8: While `fifo_en` is low, `tx_count` and `tx_trig` have no effect on the source bits.
- R9: An `evt_txw` pulse sets the transmit source bit whatever the state of `fifo_en`.
- R10: When a set, from an event or from the trigger, and a clear hit the same bit at the same edge, the bit ends set. Other bits cleared by the same write still clear.
- R11: While `rst_n` is low, `src_pend` and `mask` are zero and `irq` is low.
- R12: A write with `wr_sel` = 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied at the clock edge |
| evt_rx | input | 1 | Receive event pulse |
| evt_err | input | 1 | Error event pulse |
| evt_txw | input | 1 | Byte written to the transmit holding register |
| evt_modem | input | 1 | Modem-line event pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig | input | TRIG_W | Transmit trigger field |
| tx_count | input | CNT_W | Current transmit FIFO fill count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pending, 1 source, 2 mask, 3 none |
| wr_data | input | 4 | Write data, one bit per source |
| src_pend | output | 4 | Source-pending register |
| mask | output | 4 | Mask register |
| pend | output | 4 | Unmasked pending view |
| irq | output | 1 | Level interrupt request |

## Verification
A source bit stuck at 1 or at 0 shows on `src_pend` and `pend` at the first edge after the event or clear that should have moved it. A wrong mask value shows on `pend` and `irq` in the cycle right after the mask write. A wrong trigger scale appears only at the counts next to the level, so the bench drives counts exactly at, one above and one below each level it uses, on several channel settings. It observes the transmit bit one edge later. The priority of a set over a clear shows in the same cycle as the collision, so the bench forces collisions from both an event pulse and the trigger.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
package irq_pend_pkg;

  localparam int NSRC   = 4;
  localparam int BIT_RX = 0;
  localparam int BIT_ER = 1;
  localparam int BIT_TX = 2;
  localparam int BIT_MD = 3;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  // Scale applied to the trigger field for a given channel number.
  function automatic int chan_mult(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int mult_shift(input int m);
    case (m)
      32:      return 5;
      8:       return 3;
      2:       return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ipc_tx_trigger.sv
`timescale 1ns/1ps
module ipc_tx_trigger
  import irq_pend_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] trig,
  input  logic [CNT_W-1:0]  count,
  output logic              tx_req
);

  localparam int MULT  = chan_mult(CHANNEL);
  localparam int SHIFT = mult_shift(MULT);
  localparam int LVL_W = TRIG_W + SHIFT;
  localparam int CMP_W = (LVL_W > CNT_W) ? LVL_W : CNT_W;

  logic [CMP_W-1:0] level;
  logic [CMP_W-1:0] cnt_x;

  // Channel picks the scale at elaboration; a power-of-two scale is a shift.
  generate
    if (MULT == 0) begin : g_zero_level
      assign level = CMP_W'(trig) & {CMP_W{1'b0}};
    end else begin : g_scaled_level
      assign level = CMP_W'(trig) << SHIFT;
    end
  endgenerate

  assign cnt_x  = CMP_W'(count);
  assign tx_req = fifo_en && (cnt_x <= level);

endmodule

// File: rtl/ipc_src_bits.sv
`timescale 1ns/1ps
module ipc_src_bits
  import irq_pend_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] q
);

  generate
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)          q[b] <= 1'b0;
        else if (set_vec[b]) q[b] <= 1'b1;   // set beats clear
        else if (clr_vec[b]) q[b] <= 1'b0;
      end

      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[b] |=> q[b]);

      assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[b] && !set_vec[b]) |=> !q[b]);

      assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_vec[b] && !clr_vec[b]) |=> (q[b] == $past(q[b])));
    end
  endgenerate

endmodule

// File: rtl/ipc_mask_reg.sv
`timescale 1ns/1ps
module ipc_mask_reg
  import irq_pend_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NSRC-1:0] d,
  output logic [NSRC-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(d)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));

endmodule

// File: rtl/irq_pend_ctrl.sv
`timescale 1ns/1ps
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_rx,
  input  logic              evt_err,
  input  logic              evt_txw,
  input  logic              evt_modem,
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [NSRC-1:0]   wr_data,
  output logic [NSRC-1:0]   src_pend,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   pend,
  output logic              irq
);

  wsel_e           sel;
  logic            tx_req;
  logic            mask_wr;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;

  assign sel = wsel_e'(wr_sel);

  ipc_tx_trigger #(
    .CHANNEL (CHANNEL),
    .CNT_W   (CNT_W),
    .TRIG_W  (TRIG_W)
  ) u_trig (
    .fifo_en (fifo_en),
    .trig    (tx_trig),
    .count   (tx_count),
    .tx_req  (tx_req)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[BIT_RX] = evt_rx;
    set_vec[BIT_ER] = evt_err;
    set_vec[BIT_TX] = evt_txw | tx_req;
    set_vec[BIT_MD] = evt_modem;
  end

  // Both the pending view and the source view clear the source bits.
  always_comb begin
    clr_vec = '0;
    if (wr_en && (sel == SEL_PEND || sel == SEL_SRC)) clr_vec = wr_data;
  end

  assign mask_wr = wr_en && (sel == SEL_MASK);

  ipc_src_bits u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (src_pend)
  );

  ipc_mask_reg u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (mask_wr),
    .d     (wr_data),
    .q     (mask)
  );

  assign pend = src_pend & ~mask;
  assign irq  = |pend;

  // A rising request needs a new set or a mask change one edge before.
  assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|set_vec) || mask_wr));

  // An empty FIFO is at or below every trigger level.
  assert_empty_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && tx_count == '0) |=> src_pend[BIT_TX]);

endmodule

// File: tb/irq_pend_ctrl_test.sv
`timescale 1ns/1ps
module irq_pend_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       fen = 1'b0;
  logic [2:0] trig = '0;
  logic [7:0] cnt = '0;
  logic       wr = 1'b0;
  logic [1:0] sel = '0;
  logic [3:0] wd = '0;

  logic [3:0] src, msk, pnd;
  logic       irq;
  logic [3:0] src1, msk1, pnd1;
  logic       irq1;
  logic [3:0] src5, msk5, pnd5;
  logic       irq5;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_pend_ctrl #(.CHANNEL(0)) uut (
    .clk(clk), .rst_n(rst_n), .evt_rx(evt[0]), .evt_err(evt[1]),
    .evt_txw(evt[2]), .evt_modem(evt[3]), .fifo_en(fen), .tx_trig(trig),
    .tx_count(cnt), .wr_en(wr), .wr_sel(sel), .wr_data(wd),
    .src_pend(src), .mask(msk), .pend(pnd), .irq(irq));

  irq_pend_ctrl #(.CHANNEL(1)) uut1 (
    .clk(clk), .rst_n(rst_n), .evt_rx(evt[0]), .evt_err(evt[1]),
    .evt_txw(evt[2]), .evt_modem(evt[3]), .fifo_en(fen), .tx_trig(trig),
    .tx_count(cnt), .wr_en(wr), .wr_sel(sel), .wr_data(wd),
    .src_pend(src1), .mask(msk1), .pend(pnd1), .irq(irq1));

  irq_pend_ctrl #(.CHANNEL(5)) uut5 (
    .clk(clk), .rst_n(rst_n), .evt_rx(evt[0]), .evt_err(evt[1]),
    .evt_txw(evt[2]), .evt_modem(evt[3]), .fifo_en(fen), .tx_trig(trig),
    .tx_count(cnt), .wr_en(wr), .wr_sel(sel), .wr_data(wd),
    .src_pend(src5), .mask(msk5), .pend(pnd5), .irq(irq5));

  typedef struct packed {
    logic [3:0] evt;
    logic       fen;
    logic [2:0] trig;
    logic [7:0] cnt;
    logic       wr;
    logic [1:0] sel;
    logic [3:0] wd;
    logic [3:0] esrc;
    logic [3:0] emask;
    logic       eirq;
  } vec_t;

  localparam int NV = 19;
  // evt, fen, trig, cnt, wr, sel, wd | expected src, mask, irq
  localparam logic [31:0] VEC [0:NV-1] = '{
    {4'b0001,1'b0,3'd0,8'd0,  1'b0,2'd0,4'b0000, 4'b0001,4'b0000,1'b1},
    {4'b0010,1'b0,3'd0,8'd0,  1'b0,2'd0,4'b0000, 4'b0011,4'b0000,1'b1},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd1,4'b0001, 4'b0010,4'b0000,1'b1},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd2,4'b0010, 4'b0010,4'b0010,1'b0},
    {4'b1000,1'b0,3'd0,8'd0,  1'b0,2'd0,4'b0000, 4'b1010,4'b0010,1'b1},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd0,4'b1000, 4'b0010,4'b0010,1'b0},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd3,4'b1111, 4'b0010,4'b0010,1'b0},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd2,4'b0000, 4'b0010,4'b0000,1'b1},
    {4'b0100,1'b0,3'd0,8'd0,  1'b0,2'd0,4'b0000, 4'b0110,4'b0000,1'b1},
    {4'b0010,1'b0,3'd0,8'd0,  1'b1,2'd1,4'b0110, 4'b0010,4'b0000,1'b1},
    {4'b0000,1'b0,3'd0,8'd0,  1'b0,2'd0,4'b0000, 4'b0010,4'b0000,1'b1},
    {4'b0000,1'b1,3'd1,8'd32, 1'b0,2'd0,4'b0000, 4'b0110,4'b0000,1'b1},
    {4'b0000,1'b1,3'd1,8'd33, 1'b1,2'd1,4'b0100, 4'b0010,4'b0000,1'b1},
    {4'b0000,1'b1,3'd1,8'd31, 1'b1,2'd1,4'b0100, 4'b0110,4'b0000,1'b1},
    {4'b0000,1'b1,3'd7,8'd224,1'b1,2'd1,4'b0110, 4'b0100,4'b0000,1'b1},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd1,4'b0100, 4'b0000,4'b0000,1'b0},
    {4'b0000,1'b1,3'd0,8'd1,  1'b0,2'd0,4'b0000, 4'b0000,4'b0000,1'b0},
    {4'b0000,1'b1,3'd0,8'd0,  1'b0,2'd0,4'b0000, 4'b0100,4'b0000,1'b1},
    {4'b0000,1'b0,3'd0,8'd0,  1'b1,2'd0,4'b1111, 4'b0000,4'b0000,1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:       return "R1";
      2, 15:      return "R4";
      3, 7:       return "R5";
      4:          return "R2";
      5, 18:      return "R3";
      6:          return "R12";
      8:          return "R9";
      9, 13:      return "R10";
      10:         return "R8";
      11, 12, 14: return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] e, input logic f, input logic [2:0] t,
                       input logic [7:0] c, input logic w, input logic [1:0] s,
                       input logic [3:0] d);
    @(negedge clk);
    evt = e; fen = f; trig = t; cnt = c; wr = w; sel = s; wd = d;
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: state during reset
    check("R11", "reset state", {23'd0, src, msk, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      drive(v.evt, v.fen, v.trig, v.cnt, v.wr, v.sel, v.wd);
      check(tag_of(i), $sformatf("vector %0d src/mask/pend/irq", i),
            {19'd0, src, msk, pnd, irq},
            {19'd0, v.esrc, v.emask, v.esrc & ~v.emask, v.eirq});
    end

    // R6: count 16, field 2 -> levels 64 / 16 / 0 on channels 0 / 1 / 5
    drive(4'b0000, 1'b1, 3'd2, 8'd16, 1'b0, 2'd0, 4'b0000);
    check("R6", "tx bit ch0,ch1,ch5 at count 16",
          {29'd0, src[2], src1[2], src5[2]}, 32'b110);
    // R6: count 17 with a clear -> only channel 0 still at or below level
    drive(4'b0000, 1'b1, 3'd2, 8'd17, 1'b1, 2'd1, 4'b0100);
    check("R6", "tx bit ch0,ch1,ch5 at count 17",
          {29'd0, src[2], src1[2], src5[2]}, 32'b100);

    // R2: all sources set under a full mask stay invisible to irq
    drive(4'b0000, 1'b0, 3'd0, 8'd0, 1'b1, 2'd0, 4'b1111);
    drive(4'b0000, 1'b0, 3'd0, 8'd0, 1'b1, 2'd2, 4'b1111);
    drive(4'b1111, 1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 4'b0000);
    check("R2", "masked src/pend/irq", {23'd0, src, pnd, irq}, {23'd0, 4'b1111, 4'b0000, 1'b0});
    // R3: pending-view clear removes masked bits too
    drive(4'b0000, 1'b0, 3'd0, 8'd0, 1'b1, 2'd0, 4'b0101);
    check("R3", "clear through pending view", {28'd0, src}, {28'd0, 4'b1010});
    // R5: unmasking exposes the remaining sources next cycle
    drive(4'b0000, 1'b0, 3'd0, 8'd0, 1'b1, 2'd2, 4'b0010);
    check("R5", "pend/irq after unmask", {27'd0, pnd, irq}, {27'd0, 4'b1000, 1'b1});

    // R11: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    evt = '0; wr = 1'b0;
    @(posedge clk);
    #1;
    check("R11", "mid-run reset", {23'd0, src, msk, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R11", "after reset release", {19'd0, src, msk, pnd, irq}, 32'd0);

    done = 1'b1;
    report();
  end

endmodule